// File: doc/BRIEF.md
# Floppy Controller Data FIFO with DMA Request Sequencing

This block is the byte buffer that sits between the host bus and the floppy formatter's byte stream. In a disk-read command the formatter pushes bytes into it and the host takes them out. In a disk-write command the host fills it and the formatter pulls bytes out. The buffer holds up to `DEPTH` bytes. After any reset it behaves as a one-byte holding register with a one-byte request threshold. A configuration load switches it to full depth and sets a programmable threshold.

A small request sequencer drives the DMA request line `drq`. Its states are:

- `ST_OFF`: no execution phase. It leaves only on `exec_start`.
- `ST_IDLE`: an execution phase is running and the threshold is not met.
- `ST_REQ`: request raised. A burst counter is loaded with the threshold.
- `ST_TAIL`: request withdrawn. The last byte's data strobe is still awaited.

Its transitions are:

- IDLE→REQ when the fill or free-space condition holds.
- REQ→TAIL when the acknowledge falls while one byte of the burst remains (single-transfer mode).
- REQ→IDLE when the data strobe moves the last byte (demand mode, acknowledge already low).
- TAIL→IDLE on that strobe.
- Any state→OFF on an accepted terminal count or `soft_rst`.
- Any state→IDLE on `exec_start`, which also flushes the buffer.

Terminal count polarity and the DMA-enable gating follow the interface mode. A formatter push into a full buffer flags overrun. A formatter pull from an empty buffer flags underrun and yields a zero byte.

Top module: `fdc_dma_fifo`

## Requirements
- R1: After hardware reset, `drq`, `tc_done`, `overrun`, `underrun` and `fifo_level` are 0, and the buffer has a capacity of one byte with a request threshold of one byte.
- R2: `soft_rst` empties the buffer, drives `drq` low in the following cycle and returns the configuration to the one-byte default.
- R3: A `cfg_load` with `cfg_fifo_en`=1 gives a capacity of `DEPTH` bytes and a threshold of `cfg_thresh`+1 (0 means 1 byte, 15 means 16 bytes). In a disk-read command (`exec_dir_rd`=1) the sequencer requests once `fifo_level` ≥ threshold. Bytes leave the buffer in arrival order.
- R4: In a disk-write command (`exec_dir_rd`=0) the sequencer requests once free space (capacity − `fifo_level`) ≥ threshold. It does not request while free space is below the threshold.
- R5: Single-transfer mode: a falling edge of an active `dack_n` seen while one burst byte remains drops `drq` after that clock edge. Earlier falls leave `drq` high.
- R6: Demand mode: with `dack_n` already low, `drq` drops after the clock edge on which the data strobe (`host_rd` on disk read, `host_wr` on disk write) moves the last byte of the burst.
- R7: `if_mode` encoding is 00 AT, 01 PS/2, 10 Model 30, 11 treated as AT. Terminal count `tc_in` is active high in AT and Model 30 and active low in PS/2. It is accepted only while `dack_n` is low. Acceptance gives a one-cycle `tc_done` pulse in the next cycle and ends the execution phase, with `drq` low.
- R8: In AT and Model 30 modes with `dma_en`=0, `drq_oe` and `int_oe` are 0 and `dack_n` and `tc_in` are ignored. In PS/2 mode `drq_oe` and `int_oe` are always 1.
- R9: `exec_start` empties the buffer and clears both error flags by the next cycle.
- R10: In a disk-read command, a formatter push into a full buffer sets `overrun` and drops the byte. The buffered bytes stay readable and the sequencer keeps requesting one byte at a time until the buffer is empty.
- R11: In a disk-write command, a formatter pull from an empty buffer sets `underrun`. `fmt_out_data` reads 0 while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Reset-state request from the sequencer |
| cfg_load | input | 1 | Configuration capture strobe |
| cfg_fifo_en | input | 1 | 1 selects full depth |
| cfg_thresh | input | 4 | Threshold minus one |
| exec_start | input | 1 | Start of execution phase (flush) |
| exec_dir_rd | input | 1 | 1 disk read, 0 disk write |
| if_mode | input | 2 | Interface mode |
| dma_en | input | 1 | DMA enable control bit |
| host_rd | input | 1 | Host read data strobe |
| host_wr | input | 1 | Host write data strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at head of buffer for host |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc_in | input | 1 | Terminal count, polarity per mode |
| fmt_in_valid | input | 1 | Formatter byte push |
| fmt_in_data | input | 8 | Formatter byte in |
| fmt_out_req | input | 1 | Formatter byte pull |
| fmt_out_data | output | 8 | Byte at head of buffer for formatter |
| drq | output | 1 | DMA request |
| drq_oe | output | 1 | Drive enable for DMA request |
| int_oe | output | 1 | Drive enable for interrupt line |
| tc_done | output | 1 | Terminal count accepted pulse |
| overrun | output | 1 | Sticky overrun flag |
| underrun | output | 1 | Sticky underrun flag |
| fifo_level | output | 5 | Bytes held |

## Verification
The bench measures the exact cycle on which `drq` falls in both acknowledge styles. A sequencer that released on any acknowledge fall would cut a multi-byte burst after its first byte. One that ignored the strobe release would hold the request through a demand transfer. Terminal count is driven at both levels, with acknowledge high and low, in every mode. A swapped polarity or missing acknowledge qualification produces a stray or absent `tc_done`. The threshold tests hit the 16-byte limit and a buffer one byte short of the write threshold, where an off-by-one compare requests early. The one-byte default after each reset is probed by forcing an overrun on the second byte.

// File: rtl/fdc_fifo_pkg.sv
package fdc_fifo_pkg;

    typedef enum logic [1:0] {
        IFM_AT   = 2'b00,
        IFM_PS2  = 2'b01,
        IFM_M30  = 2'b10,
        IFM_RSVD = 2'b11
    } if_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_REQ,
        ST_TAIL
    } dma_state_e;

endpackage

// File: rtl/fdc_fifo_store.sv
module fdc_fifo_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = PTRW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic [W-1:0]    push_data,
    input  logic            pop,
    output logic [W-1:0]    pop_data,
    output logic [CNTW-1:0] level
);
    logic [W-1:0]    mem [DEPTH];
    logic [PTRW-1:0] wptr, rptr;
    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= wptr + PTRW'(1);
            if (pop)  rptr <= rptr + PTRW'(1);
            cnt <= cnt + CNTW'(push) - CNTW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wptr] <= push_data;
    end

    assign pop_data = mem[rptr];
    assign level    = cnt;
endmodule

// File: rtl/fdc_tc_qual.sv
module fdc_tc_qual
    import fdc_fifo_pkg::*;
(
    input  logic [1:0] if_mode,
    input  logic       dma_en,
    input  logic       dack_n,
    input  logic       tc_in,
    output logic       dack_act,
    output logic       tc_act,
    output logic       drq_oe,
    output logic       int_oe
);
    logic is_ps2, dma_ok, tc_lvl;

    always_comb begin
        is_ps2   = (if_mode_e'(if_mode) == IFM_PS2);
        dma_ok   = is_ps2 || dma_en;
        tc_lvl   = is_ps2 ? !tc_in : tc_in;
        dack_act = dma_ok && !dack_n;
        tc_act   = dack_act && tc_lvl;
        drq_oe   = dma_ok;
        int_oe   = dma_ok;
    end
endmodule

// File: rtl/fdc_dma_fsm.sv
module fdc_dma_fsm
    import fdc_fifo_pkg::*;
#(
    parameter int CNTW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            exec_start,
    input  logic            tc_act,
    input  logic            dack_act,
    input  logic            strobe,
    input  logic            need,
    input  logic [CNTW-1:0] burst_init,
    output logic            drq,
    output logic            tc_done
);
    dma_state_e      state, nxt;
    logic [CNTW-1:0] burst, burst_nxt;
    logic            dack_prev;
    logic            last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            burst     <= '0;
            dack_prev <= 1'b0;
            tc_done   <= 1'b0;
        end else begin
            state     <= nxt;
            burst     <= burst_nxt;
            dack_prev <= dack_act;
            tc_done   <= tc_act && !soft_rst;
        end
    end

    always_comb begin
        nxt       = state;
        burst_nxt = burst;
        last      = (burst == CNTW'(1));
        if (strobe && burst != '0) burst_nxt = burst - CNTW'(1);
        unique case (state)
            ST_OFF:  ;
            ST_IDLE: if (need) begin
                         nxt       = ST_REQ;
                         burst_nxt = burst_init;
                     end
            ST_REQ:  if (strobe && last)
                         nxt = ST_IDLE;
                     else if (dack_act && !dack_prev && last)
                         nxt = ST_TAIL;
            ST_TAIL: if (strobe) nxt = ST_IDLE;
        endcase
        if (tc_act) nxt = ST_OFF;
        if (exec_start) begin
            nxt       = ST_IDLE;
            burst_nxt = '0;
        end
        if (soft_rst) begin
            nxt       = ST_OFF;
            burst_nxt = '0;
        end
    end

    always_comb begin
        drq = (state == ST_REQ);
    end
endmodule

// File: rtl/fdc_dma_fifo.sv
module fdc_dma_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = PTRW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            cfg_load,
    input  logic            cfg_fifo_en,
    input  logic [PTRW-1:0] cfg_thresh,
    input  logic            exec_start,
    input  logic            exec_dir_rd,
    input  logic [1:0]      if_mode,
    input  logic            dma_en,
    input  logic            host_rd,
    input  logic            host_wr,
    input  logic [W-1:0]    host_wdata,
    output logic [W-1:0]    host_rdata,
    input  logic            dack_n,
    input  logic            tc_in,
    input  logic            fmt_in_valid,
    input  logic [W-1:0]    fmt_in_data,
    input  logic            fmt_out_req,
    output logic [W-1:0]    fmt_out_data,
    output logic            drq,
    output logic            drq_oe,
    output logic            int_oe,
    output logic            tc_done,
    output logic            overrun,
    output logic            underrun,
    output logic [CNTW-1:0] fifo_level
);
    logic            en_q, dir_rd_q, ovr_q, unr_q;
    logic [PTRW-1:0] thr_q;
    logic [CNTW-1:0] level, cap, thr_eff, space, burst_init;
    logic            full, empty, push, pop, strobe, moved, need, flush;
    logic [W-1:0]    push_data, head;
    logic            dack_act, tc_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; thr_q <= '0; dir_rd_q <= 1'b1;
            ovr_q <= 1'b0; unr_q <= 1'b0;
        end else if (soft_rst) begin
            en_q <= 1'b0; thr_q <= '0;
            ovr_q <= 1'b0; unr_q <= 1'b0;
        end else begin
            if (cfg_load) begin
                en_q  <= cfg_fifo_en;
                thr_q <= cfg_thresh;
            end
            if (exec_start) begin
                dir_rd_q <= exec_dir_rd;
                ovr_q    <= 1'b0;
                unr_q    <= 1'b0;
            end else begin
                if (dir_rd_q && fmt_in_valid && full)  ovr_q <= 1'b1;
                if (!dir_rd_q && fmt_out_req && empty) unr_q <= 1'b1;
            end
        end
    end

    always_comb begin
        cap        = en_q ? CNTW'(DEPTH) : CNTW'(1);
        thr_eff    = en_q ? (CNTW'(thr_q) + CNTW'(1)) : CNTW'(1);
        space      = cap - level;
        full       = (level >= cap);
        empty      = (level == '0);
        flush      = soft_rst || exec_start;
        push       = dir_rd_q ? (fmt_in_valid && !full) : (host_wr && !full);
        push_data  = dir_rd_q ? fmt_in_data : host_wdata;
        pop        = dir_rd_q ? (host_rd && !empty) : (fmt_out_req && !empty);
        strobe     = dir_rd_q ? host_rd : host_wr;
        moved      = strobe && (dir_rd_q ? !empty : !full);
        need       = dir_rd_q ? (ovr_q ? !empty : (level >= thr_eff))
                              : (!unr_q && (space >= thr_eff));
        burst_init = (dir_rd_q && ovr_q) ? CNTW'(1) : thr_eff;
    end

    fdc_fifo_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (head),
        .level     (level)
    );

    fdc_tc_qual u_tcq (
        .if_mode  (if_mode),
        .dma_en   (dma_en),
        .dack_n   (dack_n),
        .tc_in    (tc_in),
        .dack_act (dack_act),
        .tc_act   (tc_act),
        .drq_oe   (drq_oe),
        .int_oe   (int_oe)
    );

    fdc_dma_fsm #(.CNTW(CNTW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .exec_start (exec_start),
        .tc_act     (tc_act),
        .dack_act   (dack_act),
        .strobe     (moved),
        .need       (need),
        .burst_init (burst_init),
        .drq        (drq),
        .tc_done    (tc_done)
    );

    assign host_rdata   = head;
    assign fmt_out_data = empty ? '0 : head;
    assign overrun      = ovr_q;
    assign underrun     = unr_q;
    assign fifo_level   = level;
endmodule

// File: rtl/fdc_dma_fifo_chk.sv
module fdc_dma_fifo_chk #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   soft_rst,
    input logic                   exec_start,
    input logic [1:0]             if_mode,
    input logic                   dma_en,
    input logic                   dack_n,
    input logic                   drq,
    input logic                   drq_oe,
    input logic                   int_oe,
    input logic                   tc_done,
    input logic [$clog2(DEPTH):0] fifo_level
);
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!drq && fifo_level == '0));                     // R2

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(DEPTH)+1)'(DEPTH));                     // R3

    AST_TC_NEEDS_DACK: assert property (@(posedge clk) disable iff (!rst_n)
        dack_n |=> !tc_done);                                         // R7

    AST_TC_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_done) |-> !drq);                                     // R7

    AST_PS2_PINS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (if_mode == 2'b01) |-> (drq_oe && int_oe));                   // R8

    AST_DISABLED_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && if_mode != 2'b01) |=> !tc_done);                  // R8

    AST_EXEC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> (fifo_level == '0));                           // R9
endmodule

bind fdc_dma_fifo fdc_dma_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/fdc_dma_fifo_bench.sv
module fdc_dma_fifo_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 0, cfg_load = 0, cfg_fifo_en = 0;
    logic [3:0] cfg_thresh = '0;
    logic       exec_start = 0, exec_dir_rd = 1;
    logic [1:0] if_mode = 2'b00;
    logic       dma_en = 1, host_rd = 0, host_wr = 0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       dack_n = 1, tc_in = 0;
    logic       fmt_in_valid = 0;
    logic [7:0] fmt_in_data = '0;
    logic       fmt_out_req = 0;
    logic [7:0] fmt_out_data;
    logic       drq, drq_oe, int_oe, tc_done, overrun, underrun;
    logic [4:0] fifo_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_dma_fifo u_fdc_dma_fifo (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] d);
        fmt_in_valid = 1; fmt_in_data = d; tick(); fmt_in_valid = 0;
    endtask

    task automatic do_exec(input logic rd);
        exec_dir_rd = rd; exec_start = 1; tick(); exec_start = 0;
    endtask

    task automatic do_cfg(input logic en, input logic [3:0] thr);
        cfg_fifo_en = en; cfg_thresh = thr; cfg_load = 1; tick(); cfg_load = 0;
    endtask

    task automatic do_srst();
        soft_rst = 1; tick(); soft_rst = 0;
    endtask

    task automatic t_reset();
        check("R1", "drq", drq, 0);
        check("R1", "level", fifo_level, 0);
        check("R1", "overrun", overrun, 0);
        check("R1", "underrun", underrun, 0);
        check("R1", "tc_done", tc_done, 0);
    endtask

    task automatic t_default_depth();
        do_exec(1);
        push_byte(8'hA5);
        tick();
        check("R1", "drq at one byte", drq, 1);
        push_byte(8'h3C);
        check("R10", "overrun on second byte", overrun, 1);
        check("R10", "level kept", fifo_level, 1);
        dack_n = 0; tick();
        check("R5", "drq off on dack fall", drq, 0);
        check("R10", "head byte", host_rdata, 8'hA5);
        host_rd = 1; tick(); host_rd = 0; dack_n = 1; tick();
        check("R10", "drained level", fifo_level, 0);
        check("R10", "no request when empty", drq, 0);
    endtask

    task automatic t_soft_reset();
        do_srst(); do_cfg(1, 4'd3); do_exec(1);
        for (int i = 0; i < 3; i++) push_byte(8'(i));
        do_srst();
        check("R2", "level after srst", fifo_level, 0);
        check("R2", "drq after srst", drq, 0);
        do_exec(1); push_byte(8'h01); push_byte(8'h02);
        check("R2", "depth back to one", overrun, 1);
    endtask

    task automatic t_threshold_read();
        int bad = 0;
        do_srst(); do_cfg(1, 4'd15); do_exec(1);
        for (int i = 0; i < 15; i++) push_byte(8'(i*7+1));
        tick();
        check("R3", "no drq at 15 of 16", drq, 0);
        push_byte(8'(15*7+1)); tick();
        check("R3", "drq at 16", drq, 1);
        check("R3", "level 16", fifo_level, 16);
        dack_n = 0;
        for (int i = 0; i < 16; i++) begin
            if (host_rdata != 8'(i*7+1)) bad++;
            host_rd = 1; tick();
            if (i == 14) check("R6", "drq held before last", drq, 1);
            if (i == 15) check("R6", "drq off after last strobe", drq, 0);
        end
        host_rd = 0; dack_n = 1;
        check("R3", "order mismatches", bad, 0);
        check("R3", "empty after drain", fifo_level, 0);
    endtask

    task automatic t_single();
        do_srst(); do_cfg(1, 4'd2); do_exec(1);
        for (int i = 0; i < 3; i++) push_byte(8'(i+40));
        tick();
        check("R3", "drq at 3", drq, 1);
        for (int k = 0; k < 3; k++) begin
            dack_n = 0; tick();
            check("R5", "drq after dack fall", drq, (k < 2) ? 1 : 0);
            host_rd = 1; tick(); host_rd = 0; dack_n = 1; tick();
        end
        check("R5", "level after burst", fifo_level, 0);
        check("R5", "idle after burst", drq, 0);
    endtask

    task automatic t_write();
        do_srst(); do_cfg(1, 4'd1); do_exec(0); tick();
        check("R4", "drq on free space", drq, 1);
        dack_n = 0; host_wr = 1; host_wdata = 8'h11; tick();
        host_wdata = 8'h22; tick(); host_wr = 0;
        check("R6", "drq off after write strobe", drq, 0);
        check("R4", "level 2", fifo_level, 2);
        tick();
        check("R4", "drq back with space", drq, 1);
        dack_n = 1;
        check("R4", "formatter byte 1", fmt_out_data, 8'h11);
        fmt_out_req = 1; tick();
        check("R4", "formatter byte 2", fmt_out_data, 8'h22);
        tick();
        check("R11", "zero when empty", fmt_out_data, 0);
        tick(); fmt_out_req = 0;
        check("R11", "underrun flag", underrun, 1);

        do_srst(); do_cfg(1, 4'd15); do_exec(0); tick();
        dack_n = 0; host_wr = 1;
        for (int j = 0; j < 16; j++) begin host_wdata = 8'(j); tick(); end
        host_wr = 0; dack_n = 1; tick();
        check("R4", "full, no drq", drq, 0);
        fmt_out_req = 1; tick(); fmt_out_req = 0; tick();
        check("R4", "one free below 16", drq, 0);
        fmt_out_req = 1;
        for (int j = 0; j < 15; j++) tick();
        fmt_out_req = 0; tick();
        check("R4", "drq with 16 free", drq, 1);
    endtask

    task automatic t_tc();
        for (int m = 0; m < 4; m++) begin
            logic act;
            act = (m == 1) ? 1'b0 : 1'b1;
            do_srst();
            if_mode = 2'(m); tc_in = ~act;
            do_exec(1); push_byte(8'h5A); tick();
            tc_in = act; tick();
            check("R7", $sformatf("mode%0d tc with dack high", m), tc_done, 0);
            dack_n = 0; tc_in = ~act; tick();
            check("R7", $sformatf("mode%0d inactive level", m), tc_done, 0);
            tc_in = act; tick();
            check("R7", $sformatf("mode%0d tc accepted", m), tc_done, 1);
            check("R7", $sformatf("mode%0d drq after tc", m), drq, 0);
            tc_in = ~act; dack_n = 1; tick();
            check("R7", $sformatf("mode%0d pulse width", m), tc_done, 0);
        end
        tc_in = 0; if_mode = 2'b00;
    endtask

    task automatic t_dma_disable();
        do_srst(); if_mode = 2'b00; dma_en = 0; tick();
        check("R8", "AT drq_oe", drq_oe, 0);
        check("R8", "AT int_oe", int_oe, 0);
        do_exec(1); push_byte(8'h07); tick();
        dack_n = 0; tc_in = 1; tick();
        check("R8", "tc ignored", tc_done, 0);
        check("R8", "dack ignored", drq, 1);
        tick();
        check("R8", "tc still ignored", tc_done, 0);
        dack_n = 1; tc_in = 0;
        if_mode = 2'b10; #1;
        check("R8", "M30 drq_oe", drq_oe, 0);
        if_mode = 2'b01; #1;
        check("R8", "PS2 drq_oe", drq_oe, 1);
        check("R8", "PS2 int_oe", int_oe, 1);
        if_mode = 2'b00; dma_en = 1; #1;
        check("R8", "AT enabled drq_oe", drq_oe, 1);
    endtask

    task automatic t_flush();
        do_srst(); do_exec(1); push_byte(8'h01); push_byte(8'h02);
        check("R9", "overrun before flush", overrun, 1);
        do_exec(1);
        check("R9", "level after exec", fifo_level, 0);
        check("R9", "overrun cleared", overrun, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        t_reset();
        t_default_depth();
        t_soft_reset();
        t_threshold_read();
        t_single();
        t_write();
        t_tc();
        t_dma_disable();
        t_flush();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule